// File: doc/BRIEF.md
# Operand-Waiting Issue Buffer

This block sits in front of a single execution unit and holds instructions that have passed the structural check but may still be waiting for source values. Each slot records an operation code, the tag of the result it will produce, and two source operands. A source is either a value that is already known or the tag of the producer that will later supply it. Every cycle, each pending source watches the result broadcast bus and takes the value when the tags match.

Each cycle the buffer hands at most one instruction to the unit, and only when the unit is not busy. Any slot whose two sources are both known may go, so instructions can leave out of program order. When several slots qualify, the oldest goes first. An incoming instruction whose sources are both known, arriving while the unit is free and no stored slot is eligible, skips the slots entirely. It goes to the unit in the cycle it arrives, so it spends zero cycles in the buffer.

The issue side sees a ready signal that drops while every slot is occupied. A flush input empties the buffer in one cycle.

Top module: `resv_station`

## Requirements
- R1: After reset `iss_ready` is 1 and `dsp_valid` is 0.
- R2: An accepted issue with both `iss_a_rdy` and `iss_b_rdy` at 1, while `fu_busy` is 0 and no stored slot is eligible, shows up on the `dsp_*` outputs in that same cycle with its own operation, destination and operand values.
- R3: A stored instruction with a source still pending is never dispatched.
- R4: A pending source whose tag equals `cdb_tag` while `cdb_valid` is 1 takes `cdb_data` at that clock edge. The instruction can be dispatched from the following cycle onward, and not in the broadcast cycle.
- R5: An instruction issued in the same cycle as a matching broadcast takes the broadcast value for that pending source.
- R6: When several stored slots are eligible, the one issued earliest is dispatched first. This holds whatever slot positions they occupy.
- R7: An eligible younger instruction is dispatched ahead of an older one that is still waiting for a source.
- R8: While `fu_busy` is 1, `dsp_valid` stays 0 and stored instructions keep their contents.
- R9: `iss_ready` is 0 exactly when all DEPTH slots are occupied. It returns to 1 once a slot has been dispatched.
- R10: A cycle with `flush` at 1 empties every slot and ignores that cycle's issue. Afterwards nothing is dispatched until new work arrives, and `iss_ready` is 1.
- R11: Each accepted instruction reaches `dsp_*` exactly once, and at most one instruction is dispatched per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop all held instructions |
| iss_valid | input | 1 | Incoming instruction present |
| iss_ready | output | 1 | A free slot exists |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | TAG_W | Tag of the produced result |
| iss_a_rdy | input | 1 | Source A value known |
| iss_a_val | input | DATA_W | Source A value |
| iss_a_tag | input | TAG_W | Source A producer tag |
| iss_b_rdy | input | 1 | Source B value known |
| iss_b_val | input | DATA_W | Source B value |
| iss_b_tag | input | TAG_W | Source B producer tag |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W | Broadcast producer tag |
| cdb_data | input | DATA_W | Broadcast value |
| fu_busy | input | 1 | Unit cannot accept this cycle |
| dsp_valid | output | 1 | Instruction sent to the unit |
| dsp_op | output | OP_W | Sent operation code |
| dsp_dst | output | TAG_W | Sent destination tag |
| dsp_a | output | DATA_W | Sent source A value |
| dsp_b | output | DATA_W | Sent source B value |

## Verification
The assertions rely on three things about the environment. `iss_valid` is raised only while `iss_ready` is 1. A broadcast tag matches at most one producer in flight. `fu_busy` changes only between clock edges. The stimulus keeps to all three: it changes every input just after a rising edge, waits for the ready signal before issuing, and gives each outstanding producer its own tag. The scoreboard queues the expected dispatch order before it releases the unit, so any reordering, duplicate or premature dispatch shows up as a mismatch.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_SLOT   = 2'd2
  } dsp_src_e;
endpackage

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              clear_i,
  input  logic [OP_W-1:0]   in_op_i,
  input  logic [TAG_W-1:0]  in_dst_i,
  input  logic              in_a_rdy_i,
  input  logic [DATA_W-1:0] in_a_val_i,
  input  logic [TAG_W-1:0]  in_a_tag_i,
  input  logic              in_b_rdy_i,
  input  logic [DATA_W-1:0] in_b_val_i,
  input  logic [TAG_W-1:0]  in_b_tag_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              valid_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [TAG_W-1:0]  dst_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  logic              vld_q, vld_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [TAG_W-1:0]  dst_q, dst_d;
  logic              ar_q, ar_d, br_q, br_d;
  logic [DATA_W-1:0] av_q, av_d, bv_q, bv_d;
  logic [TAG_W-1:0]  at_q, at_d, bt_q, bt_d;
  logic              en;

  assign en = alloc_i | clear_i | cdb_valid_i;

  always_comb begin
    if (alloc_i) begin
      vld_d = 1'b1;
      op_d = in_op_i;       dst_d = in_dst_i;
      ar_d = in_a_rdy_i;    av_d = in_a_val_i;  at_d = in_a_tag_i;
      br_d = in_b_rdy_i;    bv_d = in_b_val_i;  bt_d = in_b_tag_i;
    end else begin
      vld_d = vld_q & ~clear_i;
      op_d = op_q;          dst_d = dst_q;
      ar_d = ar_q;          av_d = av_q;        at_d = at_q;
      br_d = br_q;          bv_d = bv_q;        bt_d = bt_q;
    end
    // wakeup applies to the stored slot and to a slot being written now
    if (vld_d && !ar_d && cdb_valid_i && (at_d == cdb_tag_i)) begin
      ar_d = 1'b1;
      av_d = cdb_data_i;
    end
    if (vld_d && !br_d && cdb_valid_i && (bt_d == cdb_tag_i)) begin
      br_d = 1'b1;
      bv_d = cdb_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      op_q  <= '0;  dst_q <= '0;
      ar_q  <= 1'b0; av_q <= '0; at_q <= '0;
      br_q  <= 1'b0; bv_q <= '0; bt_q <= '0;
    end else if (en) begin
      vld_q <= vld_d;
      op_q  <= op_d;  dst_q <= dst_d;
      ar_q  <= ar_d;  av_q <= av_d;  at_q <= at_d;
      br_q  <= br_d;  bv_q <= bv_d;  bt_q <= bt_d;
    end
  end

  assign valid_o = vld_q;
  assign ready_o = vld_q & ar_q & br_q;
  assign op_o    = op_q;
  assign dst_o   = dst_q;
  assign a_o     = av_q;
  assign b_o     = bv_q;

  // R4: a matching broadcast fills a pending source at the next edge
  assert_capture_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !ar_q && !alloc_i && !clear_i && cdb_valid_i && cdb_tag_i == at_q)
    |=> (ar_q && av_q == $past(cdb_data_i)));

  // R3: a pending source cannot wake up without its broadcast
  assert_no_false_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !br_q && !alloc_i && !(cdb_valid_i && cdb_tag_i == bt_q))
    |=> !br_q);

  // R8: a held slot keeps its instruction until it leaves
  assert_hold_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !alloc_i && !clear_i) |=> (vld_q && $stable(op_q) && $stable(dst_q)));
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] alloc_oh_i,
  input  logic [DEPTH-1:0] req_i,
  output logic [DEPTH-1:0] grant_o
);
  // older_q[i][j] set: slot i was written before slot j
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] older_d [DEPTH];
  logic             en;

  assign en = |alloc_oh_i;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (alloc_oh_i[i])      older_d[i][j] = 1'b0;
        else if (alloc_oh_i[j]) older_d[i][j] = (i != j);
        else                    older_d[i][j] = older_q[i][j];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else if (en) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= older_d[i];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_col
    logic [DEPTH-1:0] beats;
    for (genvar h = 0; h < DEPTH; h++) begin : g_row
      assign beats[h] = req_i[h] & older_q[h][g];
    end
    assign grant_o[g] = req_i[g] & ~|beats;
  end

  // R11: never more than one winner
  assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  // R6: some requester always wins
  assert_grant_when_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> (|grant_o));
endmodule

// File: rtl/resv_station.sv
module resv_station #(
  parameter int DEPTH  = 4,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              iss_a_rdy,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic              iss_b_rdy,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              fu_busy,
  output logic              dsp_valid,
  output logic [OP_W-1:0]   dsp_op,
  output logic [TAG_W-1:0]  dsp_dst,
  output logic [DATA_W-1:0] dsp_a,
  output logic [DATA_W-1:0] dsp_b
);
  import rs_pkg::*;

  logic [DEPTH-1:0]  slot_vld, slot_rdy, free_oh, alloc_oh, clear_vec, grant;
  logic [OP_W-1:0]   slot_op  [DEPTH];
  logic [TAG_W-1:0]  slot_dst [DEPTH];
  logic [DATA_W-1:0] slot_a   [DEPTH];
  logic [DATA_W-1:0] slot_b   [DEPTH];
  logic              accept, any_rdy, bypass, take_slot;
  dsp_src_e          src;

  assign iss_ready = ~&slot_vld;
  assign accept    = iss_valid & iss_ready & ~flush;
  assign any_rdy   = |slot_rdy;
  assign bypass    = accept & iss_a_rdy & iss_b_rdy & ~fu_busy & ~any_rdy;
  assign take_slot = any_rdy & ~fu_busy & ~flush;

  // lowest free slot
  always_comb begin
    free_oh = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slot_vld[i]) free_oh = '0 | (DEPTH'(1) << i);
    end
  end

  assign alloc_oh  = (accept && !bypass) ? free_oh : '0;
  assign clear_vec = flush ? '1 : (take_slot ? grant : '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    rs_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .alloc_i(alloc_oh[g]), .clear_i(clear_vec[g]),
      .in_op_i(iss_op), .in_dst_i(iss_dst),
      .in_a_rdy_i(iss_a_rdy), .in_a_val_i(iss_a_val), .in_a_tag_i(iss_a_tag),
      .in_b_rdy_i(iss_b_rdy), .in_b_val_i(iss_b_val), .in_b_tag_i(iss_b_tag),
      .cdb_valid_i(cdb_valid), .cdb_tag_i(cdb_tag), .cdb_data_i(cdb_data),
      .valid_o(slot_vld[g]), .ready_o(slot_rdy[g]),
      .op_o(slot_op[g]), .dst_o(slot_dst[g]), .a_o(slot_a[g]), .b_o(slot_b[g])
    );
  end

  rs_age_pick #(.DEPTH(DEPTH)) u_age (
    .clk(clk), .rst_n(rst_n),
    .alloc_oh_i(alloc_oh), .req_i(slot_rdy), .grant_o(grant)
  );

  always_comb begin
    if (take_slot)   src = SRC_SLOT;
    else if (bypass) src = SRC_BYPASS;
    else             src = SRC_NONE;
  end

  always_comb begin
    dsp_valid = (src != SRC_NONE);
    dsp_op = '0; dsp_dst = '0; dsp_a = '0; dsp_b = '0;
    if (src == SRC_BYPASS) begin
      dsp_op = iss_op; dsp_dst = iss_dst; dsp_a = iss_a_val; dsp_b = iss_b_val;
    end else if (src == SRC_SLOT) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (grant[i]) begin
          dsp_op  = dsp_op  | slot_op[i];
          dsp_dst = dsp_dst | slot_dst[i];
          dsp_a   = dsp_a   | slot_a[i];
          dsp_b   = dsp_b   | slot_b[i];
        end
      end
    end
  end

  // R8: a busy unit never receives work
  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fu_busy |-> !dsp_valid);

  // R10: a flush leaves every slot empty
  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (slot_vld == '0 && iss_ready));

  // R9: a full buffer that loses nothing stays closed
  assert_full_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_vld && !flush && !dsp_valid) |=> !iss_ready);

  // R11: a dispatched slot is gone the next cycle unless refilled
  assert_leaves_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_slot && !accept) |=> ($countones(slot_vld) == $countones($past(slot_vld)) - 1));
endmodule

// File: tb/test_resv_station.sv
`timescale 1ns/1ps
module test_resv_station;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, iss_valid = 1'b0, cdb_valid = 1'b0, fu_busy = 1'b0;
  logic        iss_ready, dsp_valid;
  logic [3:0]  iss_op = '0, iss_dst = '0, iss_a_tag = '0, iss_b_tag = '0, cdb_tag = '0;
  logic        iss_a_rdy = 1'b0, iss_b_rdy = 1'b0;
  logic [15:0] iss_a_val = '0, iss_b_val = '0, cdb_data = '0;
  logic [3:0]  dsp_op, dsp_dst;
  logic [15:0] dsp_a, dsp_b;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [39:0] exp_q[$];
  string       req_q[$];

  always #(CYC/2) clk = ~clk;

  resv_station i_resv_station (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
    .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .fu_busy(fu_busy), .dsp_valid(dsp_valid), .dsp_op(dsp_op), .dsp_dst(dsp_dst),
    .dsp_a(dsp_a), .dsp_b(dsp_b)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_dsp(input string req, input logic [3:0] op, input logic [3:0] dst,
                            input logic [15:0] a, input logic [15:0] b);
    exp_q.push_back({op, dst, a, b});
    req_q.push_back(req);
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] dst,
                       input logic ar, input logic [15:0] av, input logic [3:0] at,
                       input logic br, input logic [15:0] bv, input logic [3:0] bt);
    iss_valid = 1'b1; iss_op = op; iss_dst = dst;
    iss_a_rdy = ar; iss_a_val = av; iss_a_tag = at;
    iss_b_rdy = br; iss_b_val = bv; iss_b_tag = bt;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [3:0] tag, input logic [15:0] data);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_data = data;
    tick();
    cdb_valid = 1'b0;
  endtask

  // monitor: every dispatch must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && dsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected dispatch", {dsp_op, dsp_dst, dsp_a, dsp_b}, 40'h0);
        if ({dsp_op, dsp_dst, dsp_a, dsp_b} == 40'h0) begin
          n_fail++;
          $display("FAIL R11 unexpected dispatch actual=0 expected=none");
        end
      end else begin
        automatic logic [39:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(r, {dsp_op, dsp_dst, dsp_a, dsp_b}, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 iss_ready", 40'(iss_ready), 40'd1);
    check("R1 dsp_valid", 40'(dsp_valid), 40'd0);
    tick();

    // R2: zero-wait bypass in the issue cycle
    expect_dsp("R2 bypass", 4'h1, 4'h1, 16'd10, 16'd20);
    issue(4'h1, 4'h1, 1, 16'd10, 4'h0, 1, 16'd20, 4'h0);
    tick();

    // R3 / R4: wait for source B, then wake from the bus
    issue(4'h2, 4'h2, 1, 16'd5, 4'h0, 0, 16'd0, 4'h3);
    @(negedge clk); check("R3 waiting", 40'(dsp_valid), 40'd0); tick();
    @(negedge clk); check("R3 still waiting", 40'(dsp_valid), 40'd0); tick();
    expect_dsp("R4 wake by broadcast", 4'h2, 4'h2, 16'd5, 16'd77);
    cdb_valid = 1'b1; cdb_tag = 4'h3; cdb_data = 16'd77;
    @(negedge clk); check("R4 not in broadcast cycle", 40'(dsp_valid), 40'd0);
    tick(); cdb_valid = 1'b0;
    tick(); tick();

    // R5: broadcast in the issue cycle
    expect_dsp("R5 capture at issue", 4'h3, 4'h3, 16'd33, 16'd1);
    cdb_valid = 1'b1; cdb_tag = 4'h5; cdb_data = 16'd33;
    issue(4'h3, 4'h3, 0, 16'd0, 4'h5, 1, 16'd1, 4'h0);
    cdb_valid = 1'b0;
    tick(); tick();

    // R6 / R8: age order differs from slot order
    fu_busy = 1'b1;
    issue(4'h4, 4'h4, 0, 16'd0, 4'h9, 1, 16'd1, 4'h0);   // slot 0
    issue(4'h5, 4'h5, 0, 16'd0, 4'hA, 1, 16'd2, 4'h0);   // slot 1
    bcast(4'h9, 16'd91);
    @(negedge clk); check("R8 busy holds", 40'(dsp_valid), 40'd0); tick();
    expect_dsp("R8 released", 4'h4, 4'h4, 16'd91, 16'd1);
    fu_busy = 1'b0; tick(); fu_busy = 1'b1;
    issue(4'h6, 4'h6, 1, 16'd3, 4'h0, 1, 16'd4, 4'h0);   // slot 0, youngest
    bcast(4'hA, 16'd92);
    expect_dsp("R6 oldest first", 4'h5, 4'h5, 16'd92, 16'd2);
    expect_dsp("R6 younger second", 4'h6, 4'h6, 16'd3, 16'd4);
    fu_busy = 1'b0;
    tick(); tick(); tick();

    // R7 / R9: fill up, younger ready ones overtake the waiting one
    fu_busy = 1'b1;
    issue(4'h7, 4'h7, 0, 16'd0, 4'hB, 1, 16'd7, 4'h0);
    issue(4'h8, 4'h8, 1, 16'd8, 4'h0, 1, 16'd80, 4'h0);
    issue(4'h9, 4'h9, 1, 16'd9, 4'h0, 1, 16'd90, 4'h0);
    issue(4'hA, 4'hA, 1, 16'd11, 4'h0, 1, 16'd110, 4'h0);
    @(negedge clk); check("R9 full", 40'(iss_ready), 40'd0); tick();
    expect_dsp("R7 overtake 1", 4'h8, 4'h8, 16'd8, 16'd80);
    expect_dsp("R7 overtake 2", 4'h9, 4'h9, 16'd9, 16'd90);
    expect_dsp("R7 overtake 3", 4'hA, 4'hA, 16'd11, 16'd110);
    fu_busy = 1'b0;
    tick(); tick(); tick();
    @(negedge clk); check("R9 reopened", 40'(iss_ready), 40'd1); tick();
    expect_dsp("R7 waiting one last", 4'h7, 4'h7, 16'd55, 16'd7);
    bcast(4'hB, 16'd55);
    tick(); tick();

    // R10: flush drops held work
    fu_busy = 1'b1;
    issue(4'hC, 4'hC, 1, 16'd1, 4'h0, 1, 16'd2, 4'h0);
    issue(4'hD, 4'hD, 1, 16'd3, 4'h0, 1, 16'd4, 4'h0);
    flush = 1'b1; tick(); flush = 1'b0; fu_busy = 1'b0;
    @(negedge clk);
    check("R10 nothing after flush", 40'(dsp_valid), 40'd0);
    check("R10 ready after flush", 40'(iss_ready), 40'd1);
    tick();
    @(negedge clk); check("R10 still empty", 40'(dsp_valid), 40'd0); tick();

    check("R11 all expected dispatched", 40'(exp_q.size()), 40'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule